// File: doc/BRIEF.md
# Transaction Payload Fragmenter

This block takes one transaction descriptor at a time and turns it into a train of fragment descriptors. Each transaction descriptor carries a command, a byte count, a source ID and a destination ID. A read request is cut at a configurable read-request limit. Write data and returned read data are cut at a configurable payload limit. Both limits are inputs. Each one is captured when a transaction is accepted and stays fixed until that transaction's last fragment has left. The block moves no data, builds no header and checks no CRC. It emits only the descriptors that a queue or a link layer downstream needs to move and reassemble the burst.

Each fragment carries the following:
- its own byte count;
- the number of bytes sent before it;
- the number of bytes still to follow after it;
- first and last flags;
- the command and IDs of its parent transaction.

Both sides use a valid/ready handshake. After every fragment except the last, the output goes idle for exactly one cycle. A descriptor with a byte count of zero is refused: the block raises a one-cycle error pulse and emits nothing.

Top module: `payload_fragmenter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid` and `errPulse` are 0 and `inReady` is 1.
- R2: A read request (`inCmd` = 0) whose byte count is at or below the effective read-request limit comes out as one fragment. That fragment has `outBytes` equal to the byte count, `outSent` = 0, `outRemaining` = 0, and both `outFirst` and `outLast` set.
- R3: A read request larger than the effective read-request limit is split into fragments of exactly that limit. The final fragment carries the remainder. No fragment has zero bytes. The number of fragments is the byte count divided by the limit, rounded up; for example, 1024 bytes at a limit of 256 gives 4 fragments.
- R4: Commands 1 (write data), 2 (returned read data) and 3 are split the same way at the effective payload limit. For example, 1024 bytes at a limit of 64 gives 16 fragments.
- R5: On every fragment, `outSent` is the sum of the bytes of the earlier fragments and `outRemaining` is the byte count minus `outSent` minus `outBytes`. `outFirst` is 1 exactly when `outSent` is 0, and `outLast` is 1 exactly when `outRemaining` is 0.
- R6: After a fragment that is not the last is accepted, `outValid` is 0 for exactly one cycle. The next fragment then appears.
- R7: While `outValid` is 1 and `outReady` is 0, the fragment on the output holds all of its fields unchanged.
- R8: A descriptor accepted with a byte count of 0 raises `errPulse` for one cycle, in the cycle after acceptance. It produces no fragment, and `inReady` stays 1.
- R9: A limit input of 0 selects the default limit: 512 bytes for payload and 128 bytes for read requests.
- R10: The limit inputs are sampled in the acceptance cycle. Changing them while a transaction is still producing fragments has no effect on its fragments.
- R11: `inReady` drops in the cycle after a nonzero descriptor is accepted. It returns to 1 in the cycle after the last fragment's handshake.
- R12: `outCmd`, `outSrc` and `outDst` on every fragment equal the values of the accepted descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Transaction descriptor is valid |
| inReady | output | 1 | Block can accept a descriptor |
| inCmd | input | 2 | 0 read request, 1 write data, 2 read data, 3 other data |
| inSrc | input | ID_W | Source ID |
| inDst | input | ID_W | Destination ID |
| inBytes | input | LEN_W | Transaction byte count |
| cfgMaxPayload | input | LEN_W | Payload split limit, 0 selects default |
| cfgMaxReadReq | input | LEN_W | Read-request split limit, 0 selects default |
| outValid | output | 1 | Fragment descriptor is valid |
| outReady | input | 1 | Downstream takes the fragment |
| outCmd | output | 2 | Command of the parent transaction |
| outSrc | output | ID_W | Source ID of the parent transaction |
| outDst | output | ID_W | Destination ID of the parent transaction |
| outBytes | output | LEN_W | Bytes in this fragment |
| outSent | output | LEN_W | Bytes sent before this fragment |
| outRemaining | output | LEN_W | Bytes left after this fragment |
| outFirst | output | 1 | First fragment of the transaction |
| outLast | output | 1 | Last fragment of the transaction |
| errPulse | output | 1 | One-cycle pulse on a refused zero-length descriptor |

## Verification
Directed cases cover the patterns that separate the two split paths. A 1024-byte read request at limit 256 and the same size as write data and as read data at limit 64 tell the read-request limit apart from the payload limit. Byte counts equal to the limit, one above it and 1 byte probe the boundary between a single fragment and a split, and zero-valued limit inputs show whether the defaults are used. Random descriptors use mixed commands, lengths and limits, random back-pressure on `outReady`, and limit inputs scrambled during the transaction. Together they show that the limits are latched at acceptance and that stalled fragments hold still, and they check the sent and remaining counts and the idle gap on every fragment.

// File: rtl/frag_pkg.sv
package frag_pkg;

  typedef enum logic [1:0] {
    CMD_RDREQ  = 2'd0,
    CMD_WRDATA = 2'd1,
    CMD_RDDATA = 2'd2,
    CMD_OTHER  = 2'd3
  } fragCmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_GAP  = 2'd2
  } fragState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTxn;   // capture descriptor and limits
    logic advance;   // current fragment was taken
  } fragCtl_t;

endpackage

// File: rtl/frag_datapath.sv
module frag_datapath
  import frag_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int ID_W        = 4,
  parameter int DEF_PAYLOAD = 512,
  parameter int DEF_READREQ = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  fragCtl_t         ctl,
  input  logic [1:0]       inCmd,
  input  logic [ID_W-1:0]  inSrc,
  input  logic [ID_W-1:0]  inDst,
  input  logic [LEN_W-1:0] inBytes,
  input  logic [LEN_W-1:0] cfgMaxPayload,
  input  logic [LEN_W-1:0] cfgMaxReadReq,
  output logic             badDesc,
  output logic             lastFrag,
  output logic [1:0]       fragCmd,
  output logic [ID_W-1:0]  fragSrc,
  output logic [ID_W-1:0]  fragDst,
  output logic [LEN_W-1:0] fragBytes,
  output logic [LEN_W-1:0] fragSent,
  output logic [LEN_W-1:0] fragRemaining,
  output logic             fragFirst
);

  localparam logic [LEN_W-1:0] DefPayload = LEN_W'(DEF_PAYLOAD);
  localparam logic [LEN_W-1:0] DefReadReq = LEN_W'(DEF_READREQ);

  logic [LEN_W-1:0] limitSel;
  logic [LEN_W-1:0] limitQ;
  logic [LEN_W-1:0] sentQ;
  logic [LEN_W-1:0] remQ;
  logic [1:0]       cmdQ;
  logic [ID_W-1:0]  srcQ;
  logic [ID_W-1:0]  dstQ;

  // effective limit for the incoming descriptor
  always_comb begin
    if (inCmd == CMD_RDREQ) begin
      limitSel = (cfgMaxReadReq == '0) ? DefReadReq : cfgMaxReadReq;
    end else begin
      limitSel = (cfgMaxPayload == '0) ? DefPayload : cfgMaxPayload;
    end
  end

  assign badDesc = (inBytes == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitQ <= '0;
      sentQ  <= '0;
      remQ   <= '0;
      cmdQ   <= '0;
      srcQ   <= '0;
      dstQ   <= '0;
    end else if (ctl.loadTxn) begin
      limitQ <= limitSel;
      sentQ  <= '0;
      remQ   <= inBytes;
      cmdQ   <= inCmd;
      srcQ   <= inSrc;
      dstQ   <= inDst;
    end else if (ctl.advance) begin
      sentQ <= sentQ + fragBytes;
      remQ  <= remQ - fragBytes;
    end
  end

  assign lastFrag      = (remQ <= limitQ);
  assign fragBytes     = lastFrag ? remQ : limitQ;
  assign fragRemaining = remQ - fragBytes;
  assign fragSent      = sentQ;
  assign fragFirst     = (sentQ == '0);
  assign fragCmd       = cmdQ;
  assign fragSrc       = srcQ;
  assign fragDst       = dstQ;

endmodule

// File: rtl/frag_ctrl.sv
module frag_ctrl
  import frag_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     outReady,
  input  logic     badDesc,
  input  logic     lastFrag,
  output logic     inReady,
  output logic     outValid,
  output logic     errPulse,
  output fragCtl_t ctl
);

  fragState_e state;
  fragState_e stateNext;
  logic       accept;

  assign inReady  = (state == ST_IDLE);
  assign outValid = (state == ST_EMIT);
  assign accept   = inValid && inReady;

  always_comb begin
    ctl.loadTxn = accept && !badDesc;
    ctl.advance = outValid && outReady;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (ctl.loadTxn) stateNext = ST_EMIT;
      ST_EMIT: if (ctl.advance) stateNext = lastFrag ? ST_IDLE : ST_GAP;
      ST_GAP:  stateNext = ST_EMIT;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      errPulse <= 1'b0;
    end else begin
      state    <= stateNext;
      errPulse <= accept && badDesc;
    end
  end

endmodule

// File: rtl/payload_fragmenter.sv
module payload_fragmenter
  import frag_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int ID_W        = 4,
  parameter int DEF_PAYLOAD = 512,
  parameter int DEF_READREQ = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [1:0]       inCmd,
  input  logic [ID_W-1:0]  inSrc,
  input  logic [ID_W-1:0]  inDst,
  input  logic [LEN_W-1:0] inBytes,
  input  logic [LEN_W-1:0] cfgMaxPayload,
  input  logic [LEN_W-1:0] cfgMaxReadReq,
  output logic             outValid,
  input  logic             outReady,
  output logic [1:0]       outCmd,
  output logic [ID_W-1:0]  outSrc,
  output logic [ID_W-1:0]  outDst,
  output logic [LEN_W-1:0] outBytes,
  output logic [LEN_W-1:0] outSent,
  output logic [LEN_W-1:0] outRemaining,
  output logic             outFirst,
  output logic             outLast,
  output logic             errPulse
);

  fragCtl_t ctl;
  logic     badDesc;
  logic     lastFrag;

  frag_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .badDesc  (badDesc),
    .lastFrag (lastFrag),
    .inReady  (inReady),
    .outValid (outValid),
    .errPulse (errPulse),
    .ctl      (ctl)
  );

  frag_datapath #(
    .LEN_W       (LEN_W),
    .ID_W        (ID_W),
    .DEF_PAYLOAD (DEF_PAYLOAD),
    .DEF_READREQ (DEF_READREQ)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .inCmd         (inCmd),
    .inSrc         (inSrc),
    .inDst         (inDst),
    .inBytes       (inBytes),
    .cfgMaxPayload (cfgMaxPayload),
    .cfgMaxReadReq (cfgMaxReadReq),
    .badDesc       (badDesc),
    .lastFrag      (lastFrag),
    .fragCmd       (outCmd),
    .fragSrc       (outSrc),
    .fragDst       (outDst),
    .fragBytes     (outBytes),
    .fragSent      (outSent),
    .fragRemaining (outRemaining),
    .fragFirst     (outFirst)
  );

  assign outLast = lastFrag;

endmodule

// File: rtl/frag_checker.sv
module frag_checker #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [LEN_W-1:0] outBytes,
  input logic [LEN_W-1:0] outSent,
  input logic [LEN_W-1:0] outRemaining,
  input logic             outFirst,
  input logic             outLast,
  input logic             errPulse
);

  p_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !outLast |=> !outValid);

  p_refill_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outValid && !inReady |=> outValid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outBytes) && $stable(outSent)
      && $stable(outRemaining) && $stable(outLast) && $stable(outFirst));

  p_chain_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !$past(outValid) && !$past(inReady)
      |-> outSent == LEN_W'($past(outSent, 2) + $past(outBytes, 2)));

  p_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLast == (outRemaining == '0)));

  p_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outFirst == (outSent == '0)));

  p_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outBytes != '0);

  p_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> !outValid && inReady);

  p_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

endmodule

bind payload_fragmenter frag_checker #(.LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .inReady      (inReady),
  .outValid     (outValid),
  .outReady     (outReady),
  .outBytes     (outBytes),
  .outSent      (outSent),
  .outRemaining (outRemaining),
  .outFirst     (outFirst),
  .outLast      (outLast),
  .errPulse     (errPulse)
);

// File: tb/sim_payload_fragmenter.sv
`timescale 1ns/1ps
module sim_payload_fragmenter;

  localparam int LEN_W = 16;
  localparam int ID_W  = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [1:0]       inCmd = '0;
  logic [ID_W-1:0]  inSrc = '0;
  logic [ID_W-1:0]  inDst = '0;
  logic [LEN_W-1:0] inBytes = '0;
  logic [LEN_W-1:0] cfgMaxPayload = '0;
  logic [LEN_W-1:0] cfgMaxReadReq = '0;
  logic             outValid;
  logic             outReady = 1'b0;
  logic [1:0]       outCmd;
  logic [ID_W-1:0]  outSrc;
  logic [ID_W-1:0]  outDst;
  logic [LEN_W-1:0] outBytes;
  logic [LEN_W-1:0] outSent;
  logic [LEN_W-1:0] outRemaining;
  logic             outFirst;
  logic             outLast;
  logic             errPulse;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  payload_fragmenter #(.LEN_W(LEN_W), .ID_W(ID_W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCmd(inCmd), .inSrc(inSrc), .inDst(inDst), .inBytes(inBytes),
    .cfgMaxPayload(cfgMaxPayload), .cfgMaxReadReq(cfgMaxReadReq),
    .outValid(outValid), .outReady(outReady), .outCmd(outCmd),
    .outSrc(outSrc), .outDst(outDst), .outBytes(outBytes),
    .outSent(outSent), .outRemaining(outRemaining), .outFirst(outFirst),
    .outLast(outLast), .errPulse(errPulse)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int effLimit(input int cmd, input int cfgP, input int cfgR);
    if (cmd == 0) return (cfgR == 0) ? 128 : cfgR;
    return (cfgP == 0) ? 512 : cfgP;
  endfunction

  function automatic int fragCount(input int len, input int lim);
    return (len + lim - 1) / lim;
  endfunction

  // send one descriptor and collect/check all of its fragments
  task automatic runTxn(input int cmd, input int len, input int src, input int dst,
                        input int cfgP, input int cfgR, input int readyPct);
    int lim, expSent, expRem, expBytes, nFrag, guard;
    bit gapPending, stalled, done;
    string splitTag;
    lim = effLimit(cmd, cfgP, cfgR);
    splitTag = (cmd == 0) ? ((len <= lim) ? "R2" : "R3") : "R4";
    @(negedge clk);
    check(inReady == 1'b1, "R11", "inReady idle", inReady, 1);
    inValid = 1'b1; inCmd = 2'(cmd); inBytes = LEN_W'(len);
    inSrc = ID_W'(src); inDst = ID_W'(dst);
    cfgMaxPayload = LEN_W'(cfgP); cfgMaxReadReq = LEN_W'(cfgR);
    @(negedge clk);
    inValid = 1'b0;
    // scramble limits: R10 says they must not matter now
    cfgMaxPayload = LEN_W'($urandom_range(1, 300));
    cfgMaxReadReq = LEN_W'($urandom_range(1, 300));
    if (len == 0) begin
      check(errPulse == 1'b1, "R8", "errPulse", errPulse, 1);
      check(outValid == 1'b0, "R8", "no fragment", outValid, 0);
      check(inReady == 1'b1, "R8", "inReady stays", inReady, 1);
      @(negedge clk);
      check(errPulse == 1'b0, "R8", "errPulse width", errPulse, 0);
      check(outValid == 1'b0, "R8", "no fragment later", outValid, 0);
      return;
    end
    check(inReady == 1'b0, "R11", "inReady busy", inReady, 0);
    expSent = 0; expRem = len; nFrag = 0;
    gapPending = 0; stalled = 0; done = 0; guard = 0;
    while (!done && guard < 20000) begin
      guard++;
      if (gapPending) begin
        check(outValid == 1'b0, "R6", "gap cycle", outValid, 0);
        gapPending = 0;
        outReady = ($urandom_range(0, 99) < readyPct);
      end else begin
        expBytes = (expRem > lim) ? lim : expRem;
        check(outValid == 1'b1, "R6", "fragment present", outValid, 1);
        check(outBytes == LEN_W'(expBytes), stalled ? "R7" : splitTag,
              "outBytes", outBytes, expBytes);
        check(outSent == LEN_W'(expSent), "R5", "outSent", outSent, expSent);
        check(outRemaining == LEN_W'(expRem - expBytes), "R5", "outRemaining",
              outRemaining, expRem - expBytes);
        check(outFirst == (expSent == 0), "R5", "outFirst", outFirst, expSent == 0);
        check(outLast == (expRem == expBytes), "R5", "outLast", outLast, expRem == expBytes);
        check(outCmd == 2'(cmd) && outSrc == ID_W'(src) && outDst == ID_W'(dst),
              "R12", "cmd/src/dst", {outCmd, outSrc, outDst}, {cmd[1:0], src[3:0], dst[3:0]});
        outReady = ($urandom_range(0, 99) < readyPct);
        if (outReady) begin
          nFrag++;
          expSent += expBytes;
          expRem  -= expBytes;
          stalled = 0;
          if (expRem == 0) done = 1; else gapPending = 1;
        end else begin
          stalled = 1;
        end
      end
      @(negedge clk);
    end
    outReady = 1'b0;
    check(nFrag == fragCount(len, lim), (cmd == 0) ? "R3" : "R4", "fragment count",
          nFrag, fragCount(len, lim));
    check(outValid == 1'b0 && inReady == 1'b1, "R11", "idle after last",
          {outValid, inReady}, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && errPulse == 1'b0 && inReady == 1'b1, "R1",
          "reset state", {outValid, errPulse, inReady}, 1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0 && errPulse == 1'b0 && inReady == 1'b1, "R1",
          "after reset", {outValid, errPulse, inReady}, 1);

    runTxn(0, 1024, 1, 2, 64, 256, 100);   // R3: 4 request fragments
    runTxn(1, 1024, 3, 4, 64, 256, 100);   // R4: 16 write fragments
    runTxn(2, 1024, 5, 6, 64, 256, 70);    // R4: 16 read data fragments
    runTxn(0, 128, 7, 8, 0, 0, 100);       // R2 + R9: equal to default 128
    runTxn(0, 129, 7, 8, 0, 0, 100);       // R3 + R9: one above default
    runTxn(1, 1000, 2, 9, 0, 0, 50);       // R9: 512 + 488
    runTxn(0, 100, 1, 1, 0, 64, 100);      // R3 remainder 36
    runTxn(3, 1, 15, 0, 0, 0, 100);        // R4: one byte
    runTxn(1, 0, 4, 4, 64, 64, 100);       // R8: zero length
    runTxn(0, 0, 4, 4, 64, 64, 100);       // R8: zero length read
    runTxn(1, 300, 6, 6, 100, 0, 30);      // R7: heavy stall

    for (int i = 0; i < 40; i++) begin
      int cmd, len, cfgP, cfgR;
      cmd  = $urandom_range(0, 3);
      len  = ($urandom_range(0, 15) == 0) ? 0 : $urandom_range(1, 2000);
      cfgP = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(16, 600);
      cfgR = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(16, 600);
      runTxn(cmd, len, $urandom_range(0, 15), $urandom_range(0, 15),
             cfgP, cfgR, $urandom_range(30, 100));
    end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule